// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches over system software, which has to service it at regular intervals. When software enables it, the block counts ticks from a prescaled timebase, and a 3-bit field selects one of eight timeout periods. If a full period passes with no service strobe, the block first raises a warning. Configuration decides whether the warning drives the non-maskable interrupt line or the CPU-init request line. If a second full period then passes with no strobe, the block issues a reset request pulse.

Each of the two stages can be enabled on its own. An expiry can therefore end in a warning only, a reset only, or a warning followed by a reset. A sticky flag records that the watchdog caused the last reset. The system reset leaves the flag alone and only the power-on reset clears it. After a reboot, software reads the flag to learn why the system restarted. Bus decoding and the reset circuitry itself belong to the surrounding logic. This block receives its configuration as a write strobe with parallel fields and receives service as a one-cycle strobe.

Top module: `wdog_two_stage`

## Requirements
- R1: While the power-on reset is held, and on the first cycle after it, nmi_o, init_o, rst_req_o and wd_flag_o are all 0.
- R2: While the enable field is 0, the outputs nmi_o, init_o and rst_req_o stay 0, whatever service strobes arrive and however long the block waits.
- R3: The timeout is BASE_TICKS × M ticks, where M is {1, 2, 4, 8, 16, 64, 256, 1024} for select values 0 to 7. With ticks present on every cycle, a service strobe sampled at clock edge E makes the warning output rise at edge E + BASE_TICKS × M. Select value 0 gives the shortest period.
- R4: The warning drives nmi_o when the warning-kind field is 0 and drives init_o when it is 1. The warning holds at 1 while the block is in the warning stage, and the two lines are never 1 together.
- R5: When both stages are enabled, rst_req_o rises one full period after the warning rose, provided no service strobe arrives in between.
- R6: When the warning stage is disabled and the reset stage is enabled, rst_req_o rises one period after the last service strobe, and no warning is raised.
- R7: When the reset stage is disabled, the warning stays asserted for later periods and rst_req_o never rises.
- R8: A service strobe during the warning stage lowers the warning at that same clock edge and returns the block to the armed state. A full new period must then pass before the warning rises again.
- R9: Each reset request is one pulse exactly RST_CYC clock cycles wide.
- R10: wd_flag_o becomes 1 at the edge where rst_req_o rises, but only if the flag-enable field is 1. It stays 1 through sys_rst_i and is cleared only by por_i.
- R11: When the enable field is written to 0, every output except wd_flag_o is 0 from the second clock edge after the write, whatever the state.
- R12: The counter advances only on cycles where tick_i is 1. While tick_i stays 0 nothing expires. Once ticks resume, the warning rises on the tick that completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high; also clears the flag |
| sys_rst_i | input | 1 | System reset, synchronous, active high; leaves the flag alone |
| tick_i | input | 1 | Prescaled timebase tick |
| cfg_we_i | input | 1 | Write strobe for the configuration fields |
| cfg_en_i | input | 1 | Watchdog enable |
| cfg_warn_en_i | input | 1 | Enables the warning stage |
| cfg_warn_kind_i | input | 1 | Warning kind: 0 interrupt, 1 CPU init |
| cfg_bite_en_i | input | 1 | Enables the reset stage |
| cfg_flag_en_i | input | 1 | Lets the reset request set the status flag |
| cfg_sel_i | input | 3 | Timeout period select |
| kick_i | input | 1 | Service strobe |
| nmi_o | output | 1 | Non-maskable interrupt warning |
| init_o | output | 1 | CPU-init warning |
| rst_req_o | output | 1 | Reset request pulse |
| wd_flag_o | output | 1 | Sticky watchdog-caused-reset flag |

## Verification
The stage logic is exercised with four stage-enable combinations: warning with reset, reset only, warning only, and both with the enable cleared. Together these separate the escalation, direct-reset and hold paths. All eight select values are run and the exact edge of the warning is compared, so any error in the period table or an off-by-one in the count shows up. Separate runs use a service strobe inside the warning stage, a timebase stalled for many cycles, and a disable applied during the warning. These show that a strobe restarts a whole period, that counting depends on the tick and not on the clock, and that a disable overrides every other state. The flag is tested with and without its enable, and then across a system reset and a power-on reset, to separate the two reset scopes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_ARMED,
    ST_WARN,
    ST_BITE
  } wd_state_e;

  typedef struct packed {
    logic       en;
    logic       warn_en;
    logic       warn_kind;
    logic       bite_en;
    logic       flag_en;
    logic [2:0] sel;
  } wd_cfg_t;

  // Period multiplier: doubling for the first five steps, then x4 per step.
  function automatic int unsigned period_mult(input logic [2:0] sel);
    int s;
    s = int'(sel);
    if (s < 5) return 32'd1 << s;
    else       return 32'd1 << (2 * s - 4);
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    we,
  input  wd_cfg_t wr_data,
  output wd_cfg_t cfg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      cfg <= wr_data;
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] term,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= term - 1'b1;
    end else if (run && tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = run && tick && (cnt_q == '0);

  // R12
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
  import wdog_pkg::*;
#(
  parameter int RST_CYC = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  wd_cfg_t cfg,
  input  logic    kick,
  input  logic    expire,
  output logic    load,
  output logic    run,
  output logic    bite_go,
  output logic    nmi,
  output logic    init,
  output logic    rreq
);

  localparam int PW = $clog2(RST_CYC + 1);

  wd_state_e     state_q, state_d;
  logic [PW-1:0] pcnt_q;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    bite_go = 1'b0;
    if (!cfg.en) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF: begin
          state_d = ST_ARMED;
          load    = 1'b1;
        end
        ST_ARMED: begin
          if (kick) begin
            load = 1'b1;
          end else if (expire) begin
            if (cfg.warn_en) begin
              state_d = ST_WARN;
              load    = 1'b1;
            end else if (cfg.bite_en) begin
              state_d = ST_BITE;
              bite_go = 1'b1;
            end else begin
              load = 1'b1;
            end
          end
        end
        ST_WARN: begin
          if (kick) begin
            state_d = ST_ARMED;
            load    = 1'b1;
          end else if (expire) begin
            if (cfg.bite_en) begin
              state_d = ST_BITE;
              bite_go = 1'b1;
            end else begin
              load = 1'b1;
            end
          end
        end
        ST_BITE: ;
        default: state_d = ST_OFF;
      endcase
    end
  end

  assign run = (state_q == ST_ARMED) || (state_q == ST_WARN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      pcnt_q  <= '0;
      nmi     <= 1'b0;
      init    <= 1'b0;
      rreq    <= 1'b0;
    end else begin
      state_q <= state_d;
      nmi     <= (state_d == ST_WARN) && !cfg.warn_kind;
      init    <= (state_d == ST_WARN) && cfg.warn_kind;
      if (bite_go) begin
        pcnt_q <= PW'(RST_CYC - 1);
        rreq   <= 1'b1;
      end else if ((state_d == ST_BITE) && (pcnt_q != '0)) begin
        pcnt_q <= pcnt_q - 1'b1;
        rreq   <= 1'b1;
      end else begin
        pcnt_q <= '0;
        rreq   <= 1'b0;
      end
    end
  end

  // R2
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg.en |=> (state_q == ST_OFF));

  // R5
  bite_after_stage_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rreq) |-> ($past(state_q) == ST_WARN) ||
                    (($past(state_q) == ST_ARMED) && !$past(cfg.warn_en)));

  // R8
  kick_rearms_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.en && kick && (state_q == ST_WARN)) |=> (state_q == ST_ARMED));

endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic por,
  input  logic set_req,
  input  logic set_en,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (por) begin
      flag <= 1'b0;
    end else if (set_req && set_en) begin
      flag <= 1'b1;
    end
  end

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (por)
    !$fell(flag));

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 4,
  parameter int RST_CYC    = 8
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       sys_rst_i,
  input  logic       tick_i,
  input  logic       cfg_we_i,
  input  logic       cfg_en_i,
  input  logic       cfg_warn_en_i,
  input  logic       cfg_warn_kind_i,
  input  logic       cfg_bite_en_i,
  input  logic       cfg_flag_en_i,
  input  logic [2:0] cfg_sel_i,
  input  logic       kick_i,
  output logic       nmi_o,
  output logic       init_o,
  output logic       rst_req_o,
  output logic       wd_flag_o
);

  localparam int MAX_TERM = BASE_TICKS * 1024;
  localparam int CW       = $clog2(MAX_TERM + 1);

  logic          rst;
  wd_cfg_t       wr_cfg, cfg;
  logic [CW-1:0] term;
  logic          load, run, expire, bite_go;

  assign rst = por_i | sys_rst_i;

  always_comb begin
    wr_cfg.en        = cfg_en_i;
    wr_cfg.warn_en   = cfg_warn_en_i;
    wr_cfg.warn_kind = cfg_warn_kind_i;
    wr_cfg.bite_en   = cfg_bite_en_i;
    wr_cfg.flag_en   = cfg_flag_en_i;
    wr_cfg.sel       = cfg_sel_i;
  end

  assign term = CW'(BASE_TICKS * period_mult(cfg.sel));

  wdog_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we_i),
    .wr_data (wr_cfg),
    .cfg     (cfg)
  );

  wdog_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .run    (run),
    .tick   (tick_i),
    .term   (term),
    .expire (expire)
  );

  wdog_fsm #(.RST_CYC(RST_CYC)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .kick    (kick_i),
    .expire  (expire),
    .load    (load),
    .run     (run),
    .bite_go (bite_go),
    .nmi     (nmi_o),
    .init    (init_o),
    .rreq    (rst_req_o)
  );

  wdog_status u_stat (
    .clk     (clk),
    .por     (por_i),
    .set_req (bite_go),
    .set_en  (cfg.flag_en),
    .flag    (wd_flag_o)
  );

endmodule

// File: tb/wdog_two_stage_test.sv
`timescale 1ns/1ps
module wdog_two_stage_test;

  localparam int BT  = 4;
  localparam int RC  = 8;
  localparam int K_NMI  = 0;
  localparam int K_INIT = 1;
  localparam int K_RST  = 2;

  logic       clk = 1'b0;
  logic       por = 1'b1, srst = 1'b0, tick = 1'b1;
  logic       we = 1'b0, en = 1'b0, wen = 1'b0, wkind = 1'b0, ben = 1'b0, fen = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       kick = 1'b0;
  logic       nmi, init, rreq, flag;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;
  int q_kind[$];
  int q_cyc[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_two_stage #(.BASE_TICKS(BT), .RST_CYC(RC)) uut (
    .clk(clk), .por_i(por), .sys_rst_i(srst), .tick_i(tick),
    .cfg_we_i(we), .cfg_en_i(en), .cfg_warn_en_i(wen), .cfg_warn_kind_i(wkind),
    .cfg_bite_en_i(ben), .cfg_flag_en_i(fen), .cfg_sel_i(sel), .kick_i(kick),
    .nmi_o(nmi), .init_o(init), .rst_req_o(rreq), .wd_flag_o(flag)
  );

  function automatic int mult(int s);
    return (s < 5) ? (1 << s) : (1 << (2 * s - 4));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: rising edges of outputs are compared with the scoreboard.
  logic p_nmi = 0, p_init = 0, p_rreq = 0;
  int   rlen = 0;
  always @(negedge clk) begin
    int k;
    k = -1;
    if (nmi && !p_nmi)   k = K_NMI;
    if (init && !p_init) k = K_INIT;
    if (rreq && !p_rreq) k = K_RST;
    if (k >= 0) begin
      if (q_kind.size() == 0) begin
        chk(1'b0, "R2/R7 unexpected output rise", k, -1);
      end else begin
        int ek, ec;
        ek = q_kind.pop_front();
        ec = q_cyc.pop_front();
        chk(k == ek, "R4/R5/R6 event kind", k, ek);
        chk(cyc == ec, "R3/R5/R6 event edge", cyc, ec);
      end
    end
    chk(!(nmi && init), "R4 both warning lines", 1, 0);
    if (rreq) rlen++;
    else if (p_rreq) begin
      chk(rlen == RC, "R9 reset pulse width", rlen, RC);
      rlen = 0;
    end
    p_nmi = nmi; p_init = init; p_rreq = rreq;
  end

  task automatic push(input int k, input int c);
    q_kind.push_back(k);
    q_cyc.push_back(c);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit e, input bit w, input bit wk, input bit b, input bit f,
                    input int s, output int edge_no);
    @(negedge clk);
    en = e; wen = w; wkind = wk; ben = b; fen = f; sel = 3'(s); we = 1'b1;
    edge_no = cyc + 1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_kick(output int edge_no);
    @(negedge clk);
    kick = 1'b1;
    edge_no = cyc + 1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_empty(input int limit);
    int i;
    i = 0;
    while (q_kind.size() != 0 && i < limit) begin
      @(negedge clk);
      i++;
    end
    chk(q_kind.size() == 0, "R3 expected event missing", q_kind.size(), 0);
    q_kind.delete();
    q_cyc.delete();
  endtask

  task automatic sys_reset();
    @(negedge clk); srst = 1'b1;
    cycles(2);
    srst = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int e, w, k, n;
    // R1 reset state
    cycles(3);
    chk({nmi, init, rreq, flag} == 4'b0, "R1 outputs during por", int'({nmi, init, rreq, flag}), 0);
    por = 1'b0;
    @(negedge clk);
    chk({nmi, init, rreq, flag} == 4'b0, "R1 outputs after por", int'({nmi, init, rreq, flag}), 0);

    // R2 disabled: strobes and time have no effect
    wr(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 0, w);
    do_kick(e);
    cycles(60);
    chk({nmi, init, rreq} == 3'b0, "R2 disabled outputs", int'({nmi, init, rreq}), 0);

    // R3 R4 R5 R9 R10: both stages, interrupt kind, flag enabled, sel 0
    wr(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 0, w);
    cycles(3);
    do_kick(e);
    n = BT * mult(0);
    push(K_NMI, e + n);
    push(K_RST, e + 2 * n);
    wait_empty(200);
    cycles(RC + 4);
    chk(flag == 1'b1, "R10 flag set by reset request", flag, 1);
    sys_reset();
    chk(flag == 1'b1, "R10 flag survives system reset", flag, 1);
    chk({nmi, rreq} == 2'b0, "R1 outputs after system reset", int'({nmi, rreq}), 0);
    @(negedge clk); por = 1'b1;
    cycles(2); por = 1'b0;
    @(negedge clk);
    chk(flag == 1'b0, "R10 flag cleared by power-on reset", flag, 0);

    // R4 init kind, R8 kick in warning, R7 no reset stage, R11 disable
    wr(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2, w);
    cycles(3);
    do_kick(e);
    n = BT * mult(2);
    push(K_INIT, e + n);
    wait_empty(200);
    cycles(3);
    do_kick(k);
    chk(init == 1'b0, "R8 warning lowered by strobe", init, 0);
    push(K_INIT, k + n);
    wait_empty(200);
    cycles(3 * n);
    chk(init == 1'b1 && rreq == 1'b0, "R7 warning held, no reset", int'({init, rreq}), 2);
    chk(flag == 1'b0, "R7 no flag without reset", flag, 0);
    wr(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2, w);
    @(negedge clk);
    chk({nmi, init, rreq} == 3'b0, "R11 disable clears warning", int'({nmi, init, rreq}), 0);

    // R6 reset only, flag disabled
    wr(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1, w);
    cycles(3);
    do_kick(e);
    n = BT * mult(1);
    push(K_RST, e + n);
    wait_empty(200);
    cycles(RC + 4);
    chk(flag == 1'b0, "R10 flag stays clear when not enabled", flag, 0);
    sys_reset();

    // R3 all eight periods, warning only
    for (int s = 0; s < 8; s++) begin
      wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, s, w);
      cycles(3);
      do_kick(e);
      n = BT * mult(s);
      push(K_NMI, e + n);
      wait_empty(n + 20);
      chk(nmi == 1'b1, "R3 warning active for select", int'(nmi), 1);
      wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, s, w);
      cycles(2);
    end

    // R12 tick gating
    wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, w);
    cycles(3);
    @(negedge clk); tick = 1'b0;
    do_kick(e);
    cycles(50);
    chk(nmi == 1'b0, "R12 no expiry without ticks", nmi, 0);
    n = BT * mult(0);
    @(negedge clk);
    tick = 1'b1;
    push(K_NMI, cyc + 1 + n - 1);
    wait_empty(100);
    wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, w);
    cycles(5);

    done = 1;
    summary();
    $finish;
  end

endmodule